// File: doc/BRIEF.md
# Hybrid-Way Set Placement Controller

This block makes the placement and replacement decisions for one set of a set-associative, write-back cache with 64-byte lines. The set's ways come in two classes. Ways 0 to 6 are write-friendly. Ways 7 to 10 are read-friendly. The tag compare and the data arrays sit outside the block. They report each access as a one-cycle pulse that carries the access type, a hit flag and, on a hit, the way that hit.

On a miss the block picks a victim from the class that matches the access type. A write miss fills into the write-friendly class and a read miss fills into the read-friendly class. In each class the victim is that class's least recently used way. The block also keeps a dirty bit per way, so it can say whether the evicted line must be written back.

A line in a read-friendly way can take two write hits with no read hit to it in between. When that happens, the block asks the datapath to swap that line with the least recently used write-friendly line. If the displaced line is dirty, a writeback request comes one cycle before the migration request.

Top module: `hyb_place_ctrl`

## Requirements
- R1: After reset, every output is low. Dirty bits and write streaks are clear. In each class the way with the lowest local index is most recent and the way with the highest is least recent, so the first read victim is way 10 and the first write victim is way 6.
- R2: A read miss (acc_valid=1, acc_hit=0, acc_write=0) raises victim_valid one cycle later, with victim_way equal to the least recently used way among 7..10.
- R3: A write miss (acc_valid=1, acc_hit=0, acc_write=1) raises victim_valid one cycle later, with victim_way equal to the least recently used way among 0..6.
- R4: A hit, a fill or a migration destination becomes the most recently used way of its class. Ages in the other class are unchanged.
- R5: victim_dirty reports whether the victim holds modified data. A write hit or a write-miss fill marks a way dirty. A read-miss fill marks it clean.
- R6: A second write hit to a line in a read-friendly way, with no read hit to it since the first, requests a migration. mig_src is that way, mig_dst is the least recently used write-friendly way, and mig_dst becomes the most recently used write-friendly way.
- R7: A read hit to a read-friendly way clears its write streak, so the next write hit to it does not migrate.
- R8: If the migration destination is clean, mig_valid rises one cycle after the access and wb_req stays low. If it is dirty, wb_req rises one cycle after the access with wb_way = mig_dst, and mig_valid follows in the next cycle. The caller issues no access in a cycle where wb_req is high.
- R9: After a swap, the migration source way holds a clean line with a zero streak, and the destination way is dirty.
- R10: Write hits to write-friendly ways never request a migration. Accesses to other ways do not break a read-friendly line's write streak.
- R11: A hit raises neither victim_valid nor wb_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One-cycle access pulse |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_hit | input | 1 | Access hit in the set |
| acc_way | input | 4 | Way that hit (0..6 write-friendly, 7..10 read-friendly) |
| victim_valid | output | 1 | Miss victim reported |
| victim_way | output | 4 | Way chosen for the fill |
| victim_dirty | output | 1 | Victim holds modified data |
| wb_req | output | 1 | Write back the displaced line before the swap |
| wb_way | output | 4 | Way to write back |
| mig_valid | output | 1 | Swap request |
| mig_src | output | 4 | Read-friendly way that holds the migrating line |
| mig_dst | output | 4 | Write-friendly way that receives it |

## Verification
Assertions check, on every cycle, the invariants that hold at any instant:
- each class has exactly one least-recently-used way;
- a miss victim lies in the class that matches the miss type;
- migration sources and destinations lie in the correct classes;
- a writeback request is followed at once by a migration to the same way;
- a touched way is never the next victim.

Some behaviour depends on history over many accesses, and only the bench's scenarios show it:
- the exact LRU order after mixed traffic;
- whether victims are dirty;
- streak resets by read hits;
- streaks that survive accesses to other lines;
- the clean state of a swapped-in line.

// File: rtl/hyb_pkg.sv
package hyb_pkg;

    localparam int unsigned WR_WAYS_DEF = 7;
    localparam int unsigned RD_WAYS_DEF = 4;
    localparam int unsigned STREAK_DEF  = 2;

    typedef enum logic [1:0] {
        ACC_RD_MISS = 2'b00,
        ACC_WR_MISS = 2'b01,
        ACC_RD_HIT  = 2'b10,
        ACC_WR_HIT  = 2'b11
    } acc_kind_e;

    function automatic acc_kind_e decode_kind(input logic hit, input logic write);
        return acc_kind_e'({hit, write});
    endfunction

endpackage

// File: rtl/hyb_lru_class.sv
module hyb_lru_class #(
    parameter int unsigned N = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   touch_en,
    input  logic [(N > 1 ? $clog2(N) : 1)-1:0]     touch_idx,
    output logic [(N > 1 ? $clog2(N) : 1)-1:0]     lru_idx
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0][IW-1:0] age;
    } lru_st_t;

    lru_st_t       st_d, st_q;
    logic [N-1:0]  oldest;

    always_comb begin
        st_d = st_q;
        if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx) begin
                    st_d.age[i] = '0;
                end else if (st_q.age[i] < st_q.age[touch_idx]) begin
                    st_d.age[i] = st_q.age[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        oldest  = '0;
        for (int i = 0; i < N; i++) begin
            oldest[i] = (st_q.age[i] == IW'(N - 1));
            if (oldest[i]) lru_idx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) st_q.age[i] <= IW'(i);
        end else begin
            st_q <= st_d;
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1);                                        // R4
    AST_TOUCHED_NOT_LRU: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && N > 1) |=> lru_idx != $past(touch_idx));            // R4

endmodule

// File: rtl/hyb_streak.sv
module hyb_streak #(
    parameter int unsigned N     = 4,
    parameter int unsigned LIMIT = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic                                rd_en,
    input  logic                                clr_en,
    input  logic [(N > 1 ? $clog2(N) : 1)-1:0]  idx,
    output logic                                fire
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    typedef struct packed {
        logic [N-1:0][CW-1:0] cnt;
    } stk_st_t;

    stk_st_t st_d, st_q;

    assign fire = wr_en && (st_q.cnt[idx] == CW'(LIMIT - 1));

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cnt[idx] = fire ? '0 : st_q.cnt[idx] + 1'b1;
        end else if (rd_en || clr_en) begin
            st_d.cnt[idx] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> st_q.cnt[$past(idx)] == '0);                            // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> st_q.cnt[$past(idx)] == '0);               // R7
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (rd_en || clr_en)));                                  // R7

endmodule

// File: rtl/hyb_place_ctrl.sv
module hyb_place_ctrl
    import hyb_pkg::*;
#(
    parameter int unsigned WR_WAYS = WR_WAYS_DEF,
    parameter int unsigned RD_WAYS = RD_WAYS_DEF,
    parameter int unsigned STREAK  = STREAK_DEF,
    parameter int unsigned WAY_W   = $clog2(WR_WAYS + RD_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_hit,
    input  logic [WAY_W-1:0] acc_way,
    output logic             victim_valid,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_dirty,
    output logic             wb_req,
    output logic [WAY_W-1:0] wb_way,
    output logic             mig_valid,
    output logic [WAY_W-1:0] mig_src,
    output logic [WAY_W-1:0] mig_dst
);
    localparam int unsigned NW  = WR_WAYS + RD_WAYS;
    localparam int unsigned WIW = (WR_WAYS > 1) ? $clog2(WR_WAYS) : 1;
    localparam int unsigned RIW = (RD_WAYS > 1) ? $clog2(RD_WAYS) : 1;
    localparam logic [WAY_W-1:0] RD_BASE = WAY_W'(WR_WAYS);

    typedef struct packed {
        logic [NW-1:0]    dirty;
        logic             vic_v;
        logic [WAY_W-1:0] vic_way;
        logic             vic_dirty;
        logic             wb_v;
        logic [WAY_W-1:0] wb_way;
        logic             mig_v;
        logic [WAY_W-1:0] mig_src;
        logic [WAY_W-1:0] mig_dst;
        logic             pend;
        logic [WAY_W-1:0] pend_src;
        logic [WAY_W-1:0] pend_dst;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    acc_kind_e        kind;
    logic             in_rd;
    logic [WIW-1:0]   wr_local;
    logic [RIW-1:0]   rd_local;
    logic [WIW-1:0]   w_lru;
    logic [RIW-1:0]   r_lru;
    logic [WAY_W-1:0] w_lru_way;
    logic [WAY_W-1:0] r_lru_way;
    logic             rd_miss, wr_miss, rd_hit_r, wr_hit_r, wr_hit_w, rd_hit_w;
    logic             migrate;
    logic             w_touch_en, r_touch_en;
    logic [WIW-1:0]   w_touch_idx;
    logic [RIW-1:0]   r_touch_idx;
    logic             stk_wr, stk_rd, stk_clr;
    logic [RIW-1:0]   stk_idx;

    // Access classification
    always_comb begin
        kind      = decode_kind(acc_hit, acc_write);
        in_rd     = (acc_way >= RD_BASE);
        wr_local  = WIW'(acc_way);
        rd_local  = RIW'(acc_way - RD_BASE);
        w_lru_way = WAY_W'(w_lru);
        r_lru_way = RD_BASE + WAY_W'(r_lru);
        rd_miss   = acc_valid && (kind == ACC_RD_MISS);
        wr_miss   = acc_valid && (kind == ACC_WR_MISS);
        rd_hit_r  = acc_valid && (kind == ACC_RD_HIT) &&  in_rd;
        wr_hit_r  = acc_valid && (kind == ACC_WR_HIT) &&  in_rd;
        rd_hit_w  = acc_valid && (kind == ACC_RD_HIT) && !in_rd;
        wr_hit_w  = acc_valid && (kind == ACC_WR_HIT) && !in_rd;
    end

    // Per-class recency: one tracker per way class
    always_comb begin
        w_touch_en  = wr_miss || rd_hit_w || wr_hit_w || migrate;
        w_touch_idx = (wr_miss || migrate) ? w_lru : wr_local;
        r_touch_en  = rd_miss || rd_hit_r || wr_hit_r;
        r_touch_idx = rd_miss ? r_lru : rd_local;
    end

    hyb_lru_class #(.N(WR_WAYS)) u_wr_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (w_touch_en),
        .touch_idx (w_touch_idx),
        .lru_idx   (w_lru)
    );

    hyb_lru_class #(.N(RD_WAYS)) u_rd_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (r_touch_en),
        .touch_idx (r_touch_idx),
        .lru_idx   (r_lru)
    );

    // Write streaks of read-friendly lines
    always_comb begin
        stk_wr  = wr_hit_r;
        stk_rd  = rd_hit_r;
        stk_clr = rd_miss;
        stk_idx = rd_miss ? r_lru : rd_local;
    end

    hyb_streak #(.N(RD_WAYS), .LIMIT(STREAK)) u_streak (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (stk_wr),
        .rd_en  (stk_rd),
        .clr_en (stk_clr),
        .idx    (stk_idx),
        .fire   (migrate)
    );

    // Next state
    always_comb begin
        st_d           = st_q;
        st_d.vic_v     = 1'b0;
        st_d.vic_dirty = 1'b0;
        st_d.wb_v      = 1'b0;
        st_d.mig_v     = 1'b0;
        st_d.pend      = 1'b0;

        if (rd_miss || wr_miss) begin
            st_d.vic_v     = 1'b1;
            st_d.vic_way   = wr_miss ? w_lru_way : r_lru_way;
            st_d.vic_dirty = st_q.dirty[st_d.vic_way];
            st_d.dirty[st_d.vic_way] = wr_miss;
        end

        if (wr_hit_w || (wr_hit_r && !migrate)) begin
            st_d.dirty[acc_way] = 1'b1;
        end

        if (migrate) begin
            st_d.dirty[acc_way]   = 1'b0;
            st_d.dirty[w_lru_way] = 1'b1;
            if (st_q.dirty[w_lru_way]) begin
                st_d.wb_v     = 1'b1;
                st_d.wb_way   = w_lru_way;
                st_d.pend     = 1'b1;
                st_d.pend_src = acc_way;
                st_d.pend_dst = w_lru_way;
            end else begin
                st_d.mig_v   = 1'b1;
                st_d.mig_src = acc_way;
                st_d.mig_dst = w_lru_way;
            end
        end

        if (st_q.pend) begin
            st_d.mig_v   = 1'b1;
            st_d.mig_src = st_q.pend_src;
            st_d.mig_dst = st_q.pend_dst;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign victim_valid = st_q.vic_v;
    assign victim_way   = st_q.vic_way;
    assign victim_dirty = st_q.vic_dirty;
    assign wb_req       = st_q.wb_v;
    assign wb_way       = st_q.wb_way;
    assign mig_valid    = st_q.mig_v;
    assign mig_src      = st_q.mig_src;
    assign mig_dst      = st_q.mig_dst;

    AST_RD_VICTIM_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && !$past(acc_write)) |-> victim_way >= RD_BASE);  // R2
    AST_WR_VICTIM_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && $past(acc_write)) |-> victim_way < RD_BASE);    // R3
    AST_MIG_CLASSES: assert property (@(posedge clk) disable iff (!rst_n)
        mig_valid |-> (mig_src >= RD_BASE && mig_dst < RD_BASE));        // R6
    AST_WB_THEN_MIG: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |=> (mig_valid && mig_dst == $past(wb_way)));             // R8
    AST_NO_ACCESS_IN_WB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !acc_valid);                                          // R8
    AST_HIT_NO_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit) |=> !victim_valid);                       // R11

endmodule

// File: tb/hyb_place_ctrl_tb.sv
module hyb_place_ctrl_tb;

    localparam int WR = 7;
    localparam int RD = 4;
    localparam int NW = WR + RD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic       acc_hit = 1'b0;
    logic [3:0] acc_way = '0;
    logic       victim_valid, victim_dirty, wb_req, mig_valid;
    logic [3:0] victim_way, wb_way, mig_src, mig_dst;

    always #10 clk = ~clk;

    hyb_place_ctrl u_dut (
        .clk (clk), .rst_n (rst_n),
        .acc_valid (acc_valid), .acc_write (acc_write), .acc_hit (acc_hit), .acc_way (acc_way),
        .victim_valid (victim_valid), .victim_way (victim_way), .victim_dirty (victim_dirty),
        .wb_req (wb_req), .wb_way (wb_way),
        .mig_valid (mig_valid), .mig_src (mig_src), .mig_dst (mig_dst)
    );

    typedef struct {
        int    cyc;
        int    kind;   // 0 victim, 1 writeback, 2 migration
        int    a;
        int    b;
        string rq;
    } exp_t;

    exp_t  sb[$];
    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    mon_on = 1'b0;

    // Reference state
    int wl[$];
    int rl[$];
    bit dirty_m[NW];
    int streak_m[RD];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic void touch(ref int l[$], input int x);
        foreach (l[i]) if (l[i] == x) begin l.delete(i); break; end
        l.push_front(x);
    endfunction

    function automatic void push_exp(input int c, input int k, input int a, input int b, input string rq);
        exp_t e;
        e.cyc = c; e.kind = k; e.a = a; e.b = b; e.rq = rq;
        sb.push_back(e);
    endfunction

    // Driver: compute expectations, then present the access for one cycle
    task automatic access(input bit wr, input bit hit, input int way, input string rq);
        int  c;
        bit  gap;
        c   = cyc + 1;
        gap = 1'b0;
        if (!hit) begin
            int v;
            v = wr ? wl[$] : rl[$];
            push_exp(c, 0, v, dirty_m[v], rq);
            dirty_m[v] = wr;
            if (wr) touch(wl, v);
            else begin touch(rl, v); streak_m[v - WR] = 0; end
        end else if (way < WR) begin
            touch(wl, way);
            if (wr) dirty_m[way] = 1'b1;
        end else begin
            touch(rl, way);
            if (!wr) streak_m[way - WR] = 0;
            else if (streak_m[way - WR] == 1) begin
                int d;
                d = wl[$];
                streak_m[way - WR] = 0;
                if (dirty_m[d]) begin
                    push_exp(c, 1, d, 0, rq);
                    push_exp(c + 1, 2, way, d, rq);
                    gap = 1'b1;
                end else begin
                    push_exp(c, 2, way, d, rq);
                end
                dirty_m[d]   = 1'b1;
                dirty_m[way] = 1'b0;
                touch(wl, d);
            end else begin
                streak_m[way - WR] = 1;
                dirty_m[way] = 1'b1;
            end
        end
        acc_valid = 1'b1; acc_write = wr; acc_hit = hit; acc_way = 4'(way);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_hit = 1'b0; acc_way = '0;
        if (gap) @(negedge clk);
    endtask

    // Monitor: pop expected items due this cycle and compare
    always @(negedge clk) begin
        if (mon_on) begin
            for (int k = 0; k < 3; k++) begin
                int  idx;
                bit  obs;
                int  oa, ob;
                idx = -1;
                foreach (sb[i]) if (sb[i].cyc == cyc && sb[i].kind == k) idx = i;
                obs = (k == 0) ? victim_valid : (k == 1) ? wb_req : mig_valid;
                oa  = (k == 0) ? int'(victim_way) : (k == 1) ? int'(wb_way) : int'(mig_src);
                ob  = (k == 0) ? int'(victim_dirty) : (k == 1) ? 0 : int'(mig_dst);
                if (idx >= 0) begin
                    check(obs, sb[idx].rq, $sformatf("event %0d valid", k), obs, 1);
                    if (obs) begin
                        check(oa == sb[idx].a, sb[idx].rq, $sformatf("event %0d way", k), oa, sb[idx].a);
                        if (k != 1)
                            check(ob == sb[idx].b, sb[idx].rq, $sformatf("event %0d aux", k), ob, sb[idx].b);
                    end
                    sb.delete(idx);
                end else if (obs) begin
                    check(1'b0, (k == 0) ? "R11" : (k == 1) ? "R8" : "R10",
                          $sformatf("unexpected event %0d", k), 1, 0);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < WR; i++) wl.push_back(i);
        for (int i = WR; i < NW; i++) rl.push_back(i);
        foreach (dirty_m[i]) dirty_m[i] = 1'b0;
        foreach (streak_m[i]) streak_m[i] = 0;

        repeat (3) @(negedge clk);
        // R1: outputs quiet while in reset
        check(!victim_valid && !wb_req && !mig_valid, "R1", "outputs in reset",
              {victim_valid, wb_req, mig_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!victim_valid && !wb_req && !mig_valid, "R1", "outputs after reset",
              {victim_valid, wb_req, mig_valid}, 0);
        mon_on = 1'b1;

        // R1/R2: read misses cycle the read-friendly class, first victim way 10
        for (int i = 0; i < 5; i++) access(1'b0, 1'b0, 0, "R2");
        // R1/R3/R5: write misses pick write-friendly ways and mark them dirty
        for (int i = 0; i < 3; i++) access(1'b1, 1'b0, 0, "R3");
        // R4/R11: hits change recency only
        access(1'b0, 1'b1, 9, "R11");
        access(1'b0, 1'b1, 4, "R4");
        access(1'b0, 1'b0, 0, "R4");
        // R6/R8: clean destination, migration one cycle later
        access(1'b0, 1'b1, 8, "R7");
        access(1'b1, 1'b1, 8, "R6");
        access(1'b1, 1'b1, 8, "R6");
        // R7: read hit between writes breaks the streak
        access(1'b1, 1'b1, 9, "R7");
        access(1'b0, 1'b1, 9, "R7");
        access(1'b1, 1'b1, 9, "R7");
        access(1'b1, 1'b1, 9, "R6");
        // make every write-friendly way dirty
        for (int i = 0; i < 7; i++) access(1'b1, 1'b0, 0, "R5");
        // R8/R10: dirty destination, streak survives other traffic
        access(1'b1, 1'b1, 7, "R10");
        access(1'b1, 1'b1, 2, "R10");
        access(1'b0, 1'b1, 10, "R10");
        access(1'b1, 1'b1, 7, "R8");
        // R9: swapped-in line starts with zero streak and clean
        access(1'b1, 1'b1, 8, "R9");
        access(1'b1, 1'b1, 3, "R10");
        access(1'b1, 1'b1, 5, "R10");
        // R5/R9: read misses expose dirty state of read-friendly ways
        for (int i = 0; i < 4; i++) access(1'b0, 1'b0, 0, "R5");
        // back-to-back write misses with dirty victims
        for (int i = 0; i < 3; i++) access(1'b1, 1'b0, 0, "R3");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R6", "pending expected events", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule